// File: doc/BRIEF.md
# UART FIFO Control Register with Receive Threshold

This block holds the write-only FIFO control byte of a UART together with the two 16-entry byte queues it governs. One queue carries received characters from the receive shifter to the CPU. The other carries CPU-written characters to the transmit shifter. A single write port sets four things: FIFO mode, a per-queue flush, the DMA signalling mode and the receive interrupt level.

The block keeps an occupancy count for each queue. It raises a receive-data interrupt once the receive queue holds at least the programmed number of characters (1, 4, 8 or 14). With FIFO mode off, each queue shrinks to a single holding byte, and the interrupt then means "one character waiting". The serial shifters, baud timing, the character timeout and all other UART registers live outside this block.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset, fifo_en, dma_mode, rx_level, both counts, rx_irq, rx_overrun, rx_dout and tx_dout are all zero.
- R2: A control write whose bit 0 is 1 sets fifo_en, loads dma_mode from bit 3 and loads rx_level from bits 7:6. A write whose bit 0 is 0 clears fifo_en, leaves rx_level unchanged, and its bits 1, 2 and 3 have no effect.
- R3: In FIFO mode, rx_level selects the interrupt level: 00 gives 1 byte, 01 gives 4, 10 gives 8 and 11 gives 14. rx_irq is 1 in the cycle after the push that brings rx_count up to that level.
- R4: rx_irq falls in the same cycle that rx_count drops below the level, whether by a read or by a flush.
- R5: A write with bits 0 and 1 set empties the receive queue and clears rx_overrun at that edge. The flush acts once, and later pushes are counted normally.
- R6: A write with bits 0 and 2 set empties the transmit queue at that edge and leaves the receive queue untouched.
- R7: dma_mode is 1 only while fifo_en is 1. It follows bit 3 of each write that has bit 0 set.
- R8: Bits 5:4 of a control write are reserved, and their values change no output.
- R9: In FIFO mode each queue holds 16 bytes. A receive push into a full queue is dropped, leaves rx_count unchanged and sets the sticky rx_overrun flag.
- R10: Bytes leave a queue in push order, and a popped byte appears on the data output the cycle after the pop. A pop from an empty queue leaves the count at zero and the data output unchanged.
- R11: With FIFO mode off, each queue holds at most one byte: a push into an occupied holding byte is dropped, and rx_irq is 1 whenever rx_count is 1.
- R12: A write with bit 0 = 0 while fifo_en is 1 empties both queues and forces dma_mode to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| rx_push | input | 1 | Receive shifter delivers a byte |
| rx_data | input | 8 | Byte from the receive shifter |
| rx_rd | input | 1 | CPU reads one received byte |
| rx_dout | output | 8 | Last byte read from the receive queue |
| tx_wr | input | 1 | CPU writes one byte to transmit |
| tx_data | input | 8 | Byte from the CPU |
| tx_pop | input | 1 | Transmit shifter takes a byte |
| tx_dout | output | 8 | Last byte popped from the transmit queue |
| fifo_en | output | 1 | FIFO mode active |
| dma_mode | output | 1 | 0 = single-transfer DMA signalling, 1 = multi-transfer |
| rx_level | output | 2 | Stored interrupt level code |
| rx_count | output | 5 | Receive queue occupancy |
| tx_count | output | 5 | Transmit queue occupancy |
| rx_irq | output | 1 | Receive data available at or above level |
| rx_overrun | output | 1 | Sticky receive overrun flag |

## Verification
Several properties look only at cycles in which a single agent acts. The full-queue drop property assumes that no CPU read and no control write share the cycle with the overflowing push. The empty-pop property likewise assumes that no CPU write and no control write share the cycle with the pop. The stimulus honours this by issuing one control write, push or pop per cycle, with every input changed a fixed delay after the clock edge. Flush and disable properties place no constraint on the other inputs, because a flush overrides any push or pop in the same cycle.

// File: rtl/uart_fc_pkg.sv
`timescale 1ns/1ps
package uart_fc_pkg;
  // Receive interrupt level code to byte count.
  function automatic logic [4:0] lvl_bytes(input logic [1:0] code);
    case (code)
      2'b00:   lvl_bytes = 5'd1;
      2'b01:   lvl_bytes = 5'd4;
      2'b10:   lvl_bytes = 5'd8;
      default: lvl_bytes = 5'd14;
    endcase
  endfunction
endpackage

// File: rtl/uart_fc_fifo.sv
`timescale 1ns/1ps
module uart_fc_fifo #(
  parameter  int DEPTH = 16,
  parameter  int WIDTH = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             single,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count,
  output logic             overflow
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             full, empty, push_ok, pop_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    bump = (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    empty    = (count == '0);
    full     = single ? !empty : (count == CW'(DEPTH));
    push_ok  = push && !full && !clr;
    pop_ok   = pop && !empty && !clr;
    overflow = push && full && !clr;
  end

  // Storage without reset so a block RAM can hold it.
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      dout   <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok) begin
        rd_ptr <= bump(rd_ptr);
        dout   <= mem[rd_ptr];
      end
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart_fc_reg.sv
`timescale 1ns/1ps
module uart_fc_reg (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       fifo_en,
  output logic       dma_mode,
  output logic [1:0] rx_level,
  output logic       rx_clr,
  output logic       tx_clr
);
  logic wr_on, wr_off_drop;
  logic unused_rsvd;

  assign unused_rsvd = ^wr_data[5:4];

  always_comb begin
    wr_on       = wr_en && wr_data[0];
    wr_off_drop = wr_en && !wr_data[0] && fifo_en;
    // Flush strobes live for the write cycle only: nothing stores them.
    rx_clr      = (wr_on && wr_data[1]) || wr_off_drop;
    tx_clr      = (wr_on && wr_data[2]) || wr_off_drop;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_en  <= 1'b0;
      dma_mode <= 1'b0;
      rx_level <= 2'b00;
    end else if (wr_en) begin
      fifo_en <= wr_data[0];
      if (wr_data[0]) begin
        dma_mode <= wr_data[3];
        rx_level <= wr_data[7:6];
      end else begin
        dma_mode <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_fifo_ctrl.sv
`timescale 1ns/1ps
module uart_fifo_ctrl #(
  parameter  int DEPTH = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic          rx_push,
  input  logic [7:0]    rx_data,
  input  logic          rx_rd,
  output logic [7:0]    rx_dout,
  input  logic          tx_wr,
  input  logic [7:0]    tx_data,
  input  logic          tx_pop,
  output logic [7:0]    tx_dout,
  output logic          fifo_en,
  output logic          dma_mode,
  output logic [1:0]    rx_level,
  output logic [CW-1:0] rx_count,
  output logic [CW-1:0] tx_count,
  output logic          rx_irq,
  output logic          rx_overrun
);
  logic          rx_clr, tx_clr, rx_ovf, tx_ovf_unused;
  logic [CW-1:0] thr;

  uart_fc_reg u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .fifo_en(fifo_en), .dma_mode(dma_mode), .rx_level(rx_level),
    .rx_clr(rx_clr), .tx_clr(tx_clr)
  );

  uart_fc_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_rxq (
    .clk(clk), .rst(rst), .clr(rx_clr), .single(!fifo_en),
    .push(rx_push), .din(rx_data), .pop(rx_rd), .dout(rx_dout),
    .count(rx_count), .overflow(rx_ovf)
  );

  uart_fc_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_txq (
    .clk(clk), .rst(rst), .clr(tx_clr), .single(!fifo_en),
    .push(tx_wr), .din(tx_data), .pop(tx_pop), .dout(tx_dout),
    .count(tx_count), .overflow(tx_ovf_unused)
  );

  always_comb begin
    thr    = fifo_en ? CW'(uart_fc_pkg::lvl_bytes(rx_level)) : CW'(1);
    rx_irq = (rx_count != '0) && (rx_count >= thr);
  end

  always_ff @(posedge clk) begin
    if (rst)         rx_overrun <= 1'b0;
    else if (rx_clr) rx_overrun <= 1'b0;
    else if (rx_ovf) rx_overrun <= 1'b1;
  end
endmodule

// File: rtl/uart_fifo_ctrl_chk.sv
`timescale 1ns/1ps
module uart_fifo_ctrl_chk #(
  parameter  int DEPTH = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [7:0]    wr_data,
  input logic          rx_push,
  input logic          rx_rd,
  input logic          tx_wr,
  input logic          tx_pop,
  input logic [7:0]    tx_dout,
  input logic          fifo_en,
  input logic          dma_mode,
  input logic [CW-1:0] rx_count,
  input logic [CW-1:0] tx_count,
  input logic          rx_irq,
  input logic          rx_overrun
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [CW-1:0] ONE  = CW'(1);

  p_dma_needs_en_r7: assert property (@(posedge clk) disable iff (rst)
    dma_mode |-> fifo_en);

  p_rx_bound_r9: assert property (@(posedge clk) disable iff (rst)
    rx_count <= FULL);

  p_hold_one_r11: assert property (@(posedge clk) disable iff (rst)
    !fifo_en |-> (rx_count <= ONE) && (tx_count <= ONE));

  p_hold_irq_r11: assert property (@(posedge clk) disable iff (rst)
    (!fifo_en && rx_count == ONE) |-> rx_irq);

  p_empty_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (rx_count == '0) |-> !rx_irq);

  p_rx_flush_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[0] && wr_data[1]) |=> (rx_count == '0) && !rx_overrun);

  p_tx_flush_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[0] && wr_data[2]) |=> (tx_count == '0));

  p_disable_r12: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_data[0] && fifo_en) |=>
      (rx_count == '0) && (tx_count == '0) && !dma_mode);

  p_full_drop_r9: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && rx_push && !rx_rd && !wr_en && rx_count == FULL) |=>
      rx_overrun && (rx_count == FULL));

  p_empty_pop_r10: assert property (@(posedge clk) disable iff (rst)
    (tx_pop && !tx_wr && !wr_en && tx_count == '0) |=>
      $stable(tx_dout) && (tx_count == '0));
endmodule

bind uart_fifo_ctrl uart_fifo_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
  .rx_push(rx_push), .rx_rd(rx_rd), .tx_wr(tx_wr), .tx_pop(tx_pop),
  .tx_dout(tx_dout), .fifo_en(fifo_en), .dma_mode(dma_mode),
  .rx_count(rx_count), .tx_count(tx_count), .rx_irq(rx_irq),
  .rx_overrun(rx_overrun)
);

// File: tb/uart_fifo_ctrl_bench.sv
`timescale 1ns/1ps
module uart_fifo_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rx_push = 1'b0, rx_rd = 1'b0, tx_wr = 1'b0, tx_pop = 1'b0;
  logic [7:0] wr_data = '0, rx_data = '0, tx_data = '0;
  logic [7:0] rx_dout, tx_dout;
  logic       fifo_en, dma_mode, rx_irq, rx_overrun;
  logic [1:0] rx_level;
  logic [4:0] rx_count, tx_count;
  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  uart_fifo_ctrl u_uart_fifo_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rx_push(rx_push), .rx_data(rx_data), .rx_rd(rx_rd), .rx_dout(rx_dout),
    .tx_wr(tx_wr), .tx_data(tx_data), .tx_pop(tx_pop), .tx_dout(tx_dout),
    .fifo_en(fifo_en), .dma_mode(dma_mode), .rx_level(rx_level),
    .rx_count(rx_count), .tx_count(tx_count), .rx_irq(rx_irq),
    .rx_overrun(rx_overrun)
  );

  // {write value, expected fifo_en, expected dma_mode, expected level}
  localparam logic [11:0] VEC [8] = '{
    {8'hC8, 1'b0, 1'b0, 2'b00},
    {8'hC9, 1'b1, 1'b1, 2'b11},
    {8'h41, 1'b1, 1'b0, 2'b01},
    {8'hB1, 1'b1, 1'b0, 2'b10},
    {8'h48, 1'b0, 1'b0, 2'b10},
    {8'h09, 1'b1, 1'b1, 2'b00},
    {8'h30, 1'b0, 1'b0, 2'b00},
    {8'h39, 1'b1, 1'b1, 2'b00}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wreg(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d; tick(); wr_en = 1'b0;
  endtask
  task automatic rxp(input logic [7:0] d);
    rx_push = 1'b1; rx_data = d; tick(); rx_push = 1'b0;
  endtask
  task automatic rxr();
    rx_rd = 1'b1; tick(); rx_rd = 1'b0;
  endtask
  task automatic txw(input logic [7:0] d);
    tx_wr = 1'b1; tx_data = d; tick(); tx_wr = 1'b0;
  endtask
  task automatic txp();
    tx_pop = 1'b1; tick(); tx_pop = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    tick(); tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    chk("R1", "fifo_en", fifo_en, 0);
    chk("R1", "dma_mode", dma_mode, 0);
    chk("R1", "rx_level", rx_level, 0);
    chk("R1", "counts", {rx_count, tx_count}, 0);
    chk("R1", "irq/ovr", {rx_irq, rx_overrun}, 0);
    chk("R1", "douts", {rx_dout, tx_dout}, 0);

    // Register field table: R2, R7, R8
    for (int i = 0; i < 8; i++) begin
      wreg(VEC[i][11:4]);
      chk("R2", "fifo_en", fifo_en, int'(VEC[i][3]));
      chk("R7", "dma_mode", dma_mode, int'(VEC[i][2]));
      chk("R8", "rx_level", rx_level, int'(VEC[i][1:0]));
    end

    // Holding-byte mode: R11, R9, R2, R5
    wreg(8'h00);
    rxp(8'h5A);
    chk("R11", "hold count", rx_count, 1);
    chk("R11", "hold irq", rx_irq, 1);
    rxp(8'h77);
    chk("R11", "hold drop count", rx_count, 1);
    chk("R9", "hold overrun", rx_overrun, 1);
    wreg(8'h02);
    chk("R2", "flush ignored", rx_count, 1);
    rxr();
    chk("R11", "hold data", rx_dout, 8'h5A);
    chk("R4", "irq after read", rx_irq, 0);
    wreg(8'h03);
    chk("R5", "overrun cleared", rx_overrun, 0);

    // Level 4: R3, R4, R5
    wreg(8'h41);
    for (int i = 0; i < 3; i++) rxp(8'h10 + 8'(i));
    chk("R3", "irq below 4", rx_irq, 0);
    rxp(8'h13);
    chk("R3", "irq at 4", rx_irq, 1);
    rxr();
    chk("R10", "first out", rx_dout, 8'h10);
    chk("R4", "irq drop on read", rx_irq, 0);
    rxp(8'h14);
    chk("R3", "irq again", rx_irq, 1);
    wreg(8'h43);
    chk("R4", "irq on flush", rx_irq, 0);
    chk("R5", "rx flushed", rx_count, 0);
    tick();
    rxp(8'h20);
    tick();
    chk("R5", "self-clear", rx_count, 1);

    // Level 14, full queue: R3, R9, R10
    wreg(8'hC3);
    for (int i = 0; i < 13; i++) rxp(8'h30 + 8'(i));
    chk("R3", "irq at 13", rx_irq, 0);
    rxp(8'h3D);
    chk("R3", "irq at 14", rx_irq, 1);
    rxp(8'h3E); rxp(8'h3F);
    chk("R9", "full count", rx_count, 16);
    chk("R9", "no overrun yet", rx_overrun, 0);
    rxp(8'hEE);
    chk("R9", "drop count", rx_count, 16);
    chk("R9", "overrun set", rx_overrun, 1);
    for (int i = 0; i < 16; i++) begin
      rxr();
      chk("R10", "order", rx_dout, 8'h30 + i);
    end
    rxr();
    chk("R10", "empty pop count", rx_count, 0);
    chk("R10", "empty pop data", rx_dout, 8'h3F);

    // Levels 8 and 1: R3
    wreg(8'h83);
    for (int i = 0; i < 7; i++) rxp(8'h50 + 8'(i));
    chk("R3", "irq at 7", rx_irq, 0);
    rxp(8'h57);
    chk("R3", "irq at 8", rx_irq, 1);
    wreg(8'h03);
    rxp(8'h60);
    chk("R3", "irq at 1", rx_irq, 1);

    // Transmit queue: R6, R10
    txw(8'hA1); txw(8'hA2); txw(8'hA3);
    chk("R6", "tx filled", tx_count, 3);
    wreg(8'h05);
    chk("R6", "tx flushed", tx_count, 0);
    chk("R6", "rx untouched", rx_count, 1);
    txp();
    chk("R10", "tx empty pop data", tx_dout, 0);
    txw(8'hB1); txw(8'hB2);
    txp();
    chk("R10", "tx first", tx_dout, 8'hB1);
    txp();
    chk("R10", "tx second", tx_dout, 8'hB2);
    txp();
    chk("R10", "tx empty hold", {tx_count, tx_dout}, {5'd0, 8'hB2});

    // Disable with data queued: R12
    wreg(8'h09);
    rxp(8'hC1);
    txw(8'hC2); txw(8'hC3);
    chk("R12", "pre counts", {rx_count, tx_count}, {5'd2, 5'd2});
    wreg(8'h00);
    chk("R12", "counts cleared", {rx_count, tx_count}, 0);
    chk("R12", "dma cleared", dma_mode, 0);

    // Holding byte on transmit side: R11
    txw(8'hD1); txw(8'hD2);
    chk("R11", "tx hold count", tx_count, 1);
    txp();
    chk("R11", "tx hold data", tx_dout, 8'hD1);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule